// File: doc/BRIEF.md
# Near-Memory Low-Bit Gradient Aggregator

This block sits in the cache-line path of a memory controller and combines gradient lines that several training workers write to the same location. Each line is 512 bits and one line moves per beat. A group of beats is framed by first and last markers. The first beat also carries a mode and a worker count, and both hold for the whole group.

The group's mode sets how its beats are handled. An identity group returns every line unchanged. A binary group treats each bit as one gradient sign and counts the positive signs per bit position. A ternary group treats the line as 256 two-bit elements. Each element carries a gate and a sign, and the sign is counted only where the gate is set. A full-precision group takes a separate register path that never enters the counting logic.

Lines that pass through unchanged leave five cycles after they are accepted. A counting group emits one result line, five cycles after its last beat is accepted. When the consumer stalls, every stage holds and the input is refused.

Top module: `grad_agg_top`

## Requirements
- R1: Mode codes are 00 identity, 01 binary, 10 ternary and 11 full precision. Each identity beat appears on the output byte-for-byte unchanged, in the fifth cycle after it is accepted when the output is not stalled.
- R2: Each full-precision beat appears on the output unchanged, in order, with the same five-cycle latency as identity beats.
- R3: A binary group emits exactly one line, after its last beat. Bit j of that line is 1 when twice the number of beats with bit j set is at least the group's worker count, so a tie gives 1.
- R4: In ternary mode, element k sits at bits 2k+1 (gate) and 2k (sign). An element whose gate is 0 adds nothing to any count for that element.
- R5: A ternary result element is 00 when no beat had its gate set. Otherwise the gate bit is 1, and the sign bit is 1 when twice the count of gated set signs is at least the gated count.
- R6: All counts restart on a first-beat marker. Back-to-back groups do not affect each other, including the case where one group's last beat is followed directly by the next group's first beat.
- R7: Each count is 4 bits wide and saturates at 15. A group of 16 beats with a bit set in every beat, and a worker count of 15, yields 1 for that bit.
- R8: While the output is valid and not ready, the output holds its data and the input is not accepted. No beat is dropped or duplicated under back-pressure.
- R9: The mode and worker count are taken only from a first beat. The values on later beats of the same group are ignored.
- R10: After reset the output is not valid and the input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted this cycle when valid |
| in_data | input | 512 | Gradient line |
| in_mode | input | 2 | Group mode, sampled on a first beat |
| in_workers | input | 4 | Worker count for the majority threshold, sampled on a first beat |
| in_first | input | 1 | Beat opens a group |
| in_last | input | 1 | Beat closes a group |
| out_valid | output | 1 | Output line present |
| out_ready | input | 1 | Consumer takes the output line |
| out_data | output | 512 | Aggregated or passed-through line |

## Verification
Two things can happen in the same cycle. The closing beat of one group can be in the majority stage, reading the final counts, while the first beat of the next group is in the count stage, clearing and reloading those same counters. The bench provokes this by sending groups back to back with no idle cycle, including single-beat groups. It judges the outcome by comparing each result line against a behavioural model that keeps its own counts per group. The same collision is repeated under random back-pressure, so that both beats also stall together in these stages.

// File: rtl/grad_agg_pkg.sv
package grad_agg_pkg;

    localparam int WORKER_W = 8;

    typedef enum logic [1:0] {
        MODE_IDENT = 2'b00,
        MODE_BIN   = 2'b01,
        MODE_TERN  = 2'b10,
        MODE_FP32  = 2'b11
    } agg_mode_e;

    typedef struct packed {
        logic                vld;
        agg_mode_e           mode;
        logic                first;
        logic                last;
        logic [WORKER_W-1:0] workers;
    } beat_ctl_t;

    function automatic logic is_lowbit(input agg_mode_e m);
        return (m == MODE_BIN) || (m == MODE_TERN);
    endfunction

    // true when num is at least half of den (ties count as true)
    function automatic logic at_least_half(input logic [WORKER_W-1:0] num,
                                           input logic [WORKER_W-1:0] den);
        return {1'b0, num, 1'b0} >= {2'b00, den};
    endfunction

endpackage

// File: rtl/grad_agg_delay.sv
module grad_agg_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
        end else if (en) begin
            pipe[0] <= d;
            for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[DEPTH-1];
endmodule

// File: rtl/grad_agg_counters.sv
module grad_agg_counters import grad_agg_pkg::*; #(
    parameter int LINE_W = 512,
    parameter int CNT_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd,
    input  logic                    clr,
    input  agg_mode_e               mode,
    input  logic [LINE_W-1:0]       data,
    output logic [LINE_W*CNT_W-1:0] cnt_flat
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    for (genvar i = 0; i < LINE_W; i++) begin : g_lane
        logic             inc;
        logic [CNT_W-1:0] cnt, base;

        // even lane counts gated set signs, odd lane counts gates in ternary mode
        if (i % 2 == 0) begin : g_even
            assign inc = (mode == MODE_TERN) ? (data[i] & data[i+1]) : data[i];
        end else begin : g_odd
            assign inc = data[i];
        end

        assign base = clr ? '0 : cnt;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt <= '0;
            end else if (upd) begin
                cnt <= (inc && base != CNT_MAX) ? base + 1'b1 : base;
            end
        end

        assign cnt_flat[i*CNT_W +: CNT_W] = cnt;
    end
endmodule

// File: rtl/grad_agg_resolve.sv
module grad_agg_resolve import grad_agg_pkg::*; #(
    parameter int LINE_W = 512,
    parameter int CNT_W  = 4
) (
    input  logic [LINE_W*CNT_W-1:0] cnt_flat,
    input  agg_mode_e               mode,
    input  logic [WORKER_W-1:0]     workers,
    output logic [LINE_W-1:0]       line
);
    localparam int PAIRS = LINE_W / 2;

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        logic [CNT_W-1:0] c_lo, c_hi;
        logic             bin_lo, bin_hi, gate, sgn;

        assign c_lo   = cnt_flat[(2*k)*CNT_W +: CNT_W];
        assign c_hi   = cnt_flat[(2*k+1)*CNT_W +: CNT_W];
        assign bin_lo = at_least_half(WORKER_W'(c_lo), workers);
        assign bin_hi = at_least_half(WORKER_W'(c_hi), workers);
        assign gate   = (c_hi != '0);
        assign sgn    = gate && at_least_half(WORKER_W'(c_lo), WORKER_W'(c_hi));

        assign line[2*k+1:2*k] = (mode == MODE_TERN) ? {gate, sgn} : {bin_hi, bin_lo};
    end
endmodule

// File: rtl/grad_agg_top.sv
module grad_agg_top import grad_agg_pkg::*; #(
    parameter int LINE_W = 512,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [LINE_W-1:0] in_data,
    input  logic [1:0]        in_mode,
    input  logic [CNT_W-1:0]  in_workers,
    input  logic              in_first,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [LINE_W-1:0] out_data
);
    localparam int PASS_STAGES = 5;
    localparam int TAIL_STAGES = PASS_STAGES - 2;

    logic                adv, acc;
    agg_mode_e           grp_mode, eff_mode;
    logic [WORKER_W-1:0] grp_workers, eff_workers;

    assign adv      = !(out_valid && !out_ready);
    assign in_ready = adv;
    assign acc      = in_valid && adv;

    // group mode and worker count change only on a first beat
    assign eff_mode    = in_first ? agg_mode_e'(in_mode) : grp_mode;
    assign eff_workers = in_first ? WORKER_W'(in_workers) : grp_workers;

    always_ff @(posedge clk) begin
        if (rst) begin
            grp_mode    <= MODE_IDENT;
            grp_workers <= '0;
        end else if (acc && in_first) begin
            grp_mode    <= eff_mode;
            grp_workers <= eff_workers;
        end
    end

    // stage 1: captured beat (full-precision beats are not entered here)
    beat_ctl_t         s1_ctl;
    logic [LINE_W-1:0] s1_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_ctl  <= '0;
            s1_data <= '0;
        end else if (adv) begin
            s1_ctl.vld     <= acc && (eff_mode != MODE_FP32);
            s1_ctl.mode    <= eff_mode;
            s1_ctl.first   <= in_first;
            s1_ctl.last    <= in_last;
            s1_ctl.workers <= eff_workers;
            s1_data        <= in_data;
        end
    end

    // stage 2: counters update while the beat moves on
    logic [LINE_W*CNT_W-1:0] cnt_flat;

    grad_agg_counters #(.LINE_W(LINE_W), .CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .upd      (adv && s1_ctl.vld && is_lowbit(s1_ctl.mode)),
        .clr      (s1_ctl.first),
        .mode     (s1_ctl.mode),
        .data     (s1_data),
        .cnt_flat (cnt_flat)
    );

    logic                s2_vld, s2_last;
    agg_mode_e           s2_mode;
    logic [WORKER_W-1:0] s2_workers;
    logic [LINE_W-1:0]   s2_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_vld     <= 1'b0;
            s2_last    <= 1'b0;
            s2_mode    <= MODE_IDENT;
            s2_workers <= '0;
            s2_data    <= '0;
        end else if (adv) begin
            s2_vld     <= s1_ctl.vld;
            s2_last    <= s1_ctl.last;
            s2_mode    <= s1_ctl.mode;
            s2_workers <= s1_ctl.workers;
            s2_data    <= s1_data;
        end
    end

    // stage 3 input: majority over counters that already hold stage 2's beat
    logic [LINE_W-1:0] res_line, s3_data_c;
    logic              s3_vld_c;

    grad_agg_resolve #(.LINE_W(LINE_W), .CNT_W(CNT_W)) res_i (
        .cnt_flat (cnt_flat),
        .mode     (s2_mode),
        .workers  (s2_workers),
        .line     (res_line)
    );

    assign s3_vld_c  = s2_vld && ((s2_mode == MODE_IDENT) || s2_last);
    assign s3_data_c = (s2_mode == MODE_IDENT) ? s2_data : res_line;

    // stages 3 to 5 of the low-bit path
    logic [LINE_W:0] lb_q, fp_q;

    grad_agg_delay #(.W(LINE_W + 1), .DEPTH(TAIL_STAGES)) tail_i (
        .clk (clk),
        .rst (rst),
        .en  (adv),
        .d   ({s3_vld_c, s3_data_c}),
        .q   (lb_q)
    );

    // full-precision bypass of equal depth, no contact with the counters
    grad_agg_delay #(.W(LINE_W + 1), .DEPTH(PASS_STAGES)) fp_i (
        .clk (clk),
        .rst (rst),
        .en  (adv),
        .d   ({acc && (eff_mode == MODE_FP32), in_data}),
        .q   (fp_q)
    );

    assign out_valid = lb_q[LINE_W] | fp_q[LINE_W];
    assign out_data  = fp_q[LINE_W] ? fp_q[LINE_W-1:0] : lb_q[LINE_W-1:0];
endmodule

// File: rtl/grad_agg_chk.sv
module grad_agg_chk #(
    parameter int LINE_W = 512
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [LINE_W-1:0] in_data,
    input logic [1:0]        in_mode,
    input logic              in_first,
    input logic              out_valid,
    input logic              out_ready,
    input logic [LINE_W-1:0] out_data
);
    logic [2:0] since_rst;
    logic       pass_first;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    assign pass_first = in_valid && in_ready && in_first &&
                        ((in_mode == 2'b00) || (in_mode == 2'b11));

    AST_PASS_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd6 && $past(pass_first, 5) && $past(in_ready, 4) &&
         $past(in_ready, 3) && $past(in_ready, 2) && $past(in_ready, 1))
        |-> out_valid); // R1

    AST_PASS_DATA: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd6 && $past(pass_first, 5) && $past(in_ready, 4) &&
         $past(in_ready, 3) && $past(in_ready, 2) && $past(in_ready, 1))
        |-> out_data == $past(in_data, 5)); // R2

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8

    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready); // R8

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3'd0) |-> (!out_valid && in_ready)); // R10
endmodule

bind grad_agg_top grad_agg_chk #(.LINE_W(LINE_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_mode   (in_mode),
    .in_first  (in_first),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/grad_agg_top_tb_top.sv
`timescale 1ns/1ps
module grad_agg_top_tb_top;
    localparam int LW = 512;
    localparam int NE = LW / 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [LW-1:0] in_data = '0;
    logic [1:0]    in_mode = 2'b00;
    logic [3:0]    in_workers = 4'd0;
    logic          in_first = 1'b0;
    logic          in_last = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [LW-1:0] out_data;

    always #2 clk = ~clk;

    grad_agg_top dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_mode(in_mode), .in_workers(in_workers),
        .in_first(in_first), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    int  checks = 0, fails = 0, cyc = 0;
    bit  stall_en = 0, lat_chk = 1, done = 0;

    logic [LW-1:0] exp_q [$];
    string         tag_q [$];
    int            acc_q [$];

    // behavioural reference state
    int bpos [LW];
    int tpos [NE];
    int tgat [NE];
    int gm = 0, gw = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
    endtask

    task automatic chk_line(bit ok, string tag, logic [LW-1:0] act, logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_int(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] rand_line();
        logic [LW-1:0] r;
        for (int i = 0; i < LW / 32; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    task automatic push_exp(logic [LW-1:0] v, string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
        acc_q.push_back(cyc);
    endtask

    task automatic model(logic [LW-1:0] d, int m, int w, bit f, bit l, string tag);
        logic [LW-1:0] r;
        if (f) begin
            gm = m;
            gw = w;
            for (int j = 0; j < LW; j++) bpos[j] = 0;
            for (int k = 0; k < NE; k++) begin tpos[k] = 0; tgat[k] = 0; end
        end
        if (gm == 0 || gm == 3) begin
            push_exp(d, tag);
        end else if (gm == 1) begin
            for (int j = 0; j < LW; j++) if (d[j] && bpos[j] < 15) bpos[j]++;
            if (l) begin
                for (int j = 0; j < LW; j++) r[j] = (2 * bpos[j] >= gw);
                push_exp(r, tag);
            end
        end else begin
            for (int k = 0; k < NE; k++) begin
                if (d[2*k+1]) begin
                    if (tgat[k] < 15) tgat[k]++;
                    if (d[2*k] && tpos[k] < 15) tpos[k]++;
                end
            end
            if (l) begin
                for (int k = 0; k < NE; k++) begin
                    r[2*k+1] = (tgat[k] != 0);
                    r[2*k]   = (tgat[k] != 0) && (2 * tpos[k] >= tgat[k]);
                end
                push_exp(r, tag);
            end
        end
    endtask

    task automatic send(logic [LW-1:0] d, int m, int w, bit f, bit l, string tag);
        @(negedge clk); #1;
        in_valid   = 1'b1;
        in_data    = d;
        in_mode    = m[1:0];
        in_workers = w[3:0];
        in_first   = f;
        in_last    = l;
        while (!in_ready) begin @(negedge clk); #1; end
        model(d, m, w, f, l, tag);
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while (exp_q.size() != 0 && n < 2000) begin @(negedge clk); n++; end
        repeat (8) @(negedge clk);
    endtask

    // output monitor and reference comparison every cycle
    always @(negedge clk) begin : mon
        logic [LW-1:0] e;
        string         t;
        int            a;
        if (rst) begin
            out_ready = 1'b1;
        end else begin
            out_ready = stall_en ? ($urandom % 3 != 0) : 1'b1;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL R8 extra output beat act=%h exp=none", out_data);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    a = acc_q.pop_front();
                    chk_line(out_data === e, t, out_data, e);
                    if (lat_chk) chk_int(cyc - a == 5, {t, " latency"}, cyc - a, 5);
                end
            end
        end
    end

    always @(posedge clk) begin
        if (!done && cyc > 100000) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL R8 watchdog expired act=%0d exp=%0d", cyc, 100000);
            summary();
            $finish;
        end
    end

    initial begin
        logic [LW-1:0] a, b, c;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk); #1;
        chk_int(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
        chk_int(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);

        // R1 identity group of three beats
        send(rand_line(), 0, 3, 1, 0, "R1 identity");
        send(rand_line(), 0, 3, 0, 0, "R1 identity");
        send(rand_line(), 0, 3, 0, 1, "R1 identity");
        idle(); drain();

        // R2 full-precision beats
        send(rand_line(), 3, 2, 1, 0, "R2 bypass");
        send(rand_line(), 3, 2, 0, 1, "R2 bypass");
        idle(); drain();

        // R3 binary majority, five workers
        for (int i = 0; i < 5; i++) send(rand_line(), 1, 5, i == 0, i == 4, "R3 binary");
        idle(); drain();

        // R3 tie: each lane set in exactly two of four beats gives all ones
        a = rand_line();
        send(a, 1, 4, 1, 0, "R3 tie");
        send(a, 1, 4, 0, 0, "R3 tie");
        send(~a, 1, 4, 0, 0, "R3 tie");
        send(~a, 1, 4, 0, 1, "R3 tie");
        idle(); drain();

        // R4 R5 ternary random, then half the elements never gated
        for (int i = 0; i < 6; i++) send(rand_line(), 2, 6, i == 0, i == 5, "R4 R5 ternary");
        for (int i = 0; i < 3; i++) begin
            b = rand_line();
            for (int k = 0; k < NE / 2; k++) b[2*k+1] = 1'b0;
            send(b, 2, 3, i == 0, i == 2, "R5 ternary ungated");
        end
        idle(); drain();

        // R6 back-to-back groups, last beat of one directly followed by next first
        send(rand_line(), 1, 1, 1, 1, "R6 single binary");
        send(rand_line(), 2, 2, 1, 0, "R6 ternary after binary");
        send(rand_line(), 2, 2, 0, 1, "R6 ternary after binary");
        send(rand_line(), 1, 3, 1, 1, "R6 binary after ternary");
        send(rand_line(), 0, 1, 1, 1, "R6 identity after binary");
        send(rand_line(), 1, 2, 1, 0, "R6 binary restart");
        send(rand_line(), 1, 2, 0, 1, "R6 binary restart");
        idle(); drain();

        // R9 mode and worker count on later beats ignored
        a = rand_line(); b = rand_line(); c = rand_line();
        send(a, 1, 3, 1, 0, "R9 mode held");
        send(b, 3, 15, 0, 0, "R9 mode held");
        send(c, 2, 1, 0, 1, "R9 mode held");
        idle(); drain();

        // R7 saturation: sixteen all-ones beats with fifteen workers
        for (int i = 0; i < 16; i++) send('1, 1, 15, i == 0, i == 15, "R7 saturate");
        for (int i = 0; i < 15; i++) send(rand_line(), 1, 15, i == 0, i == 14, "R7 fifteen workers");
        idle(); drain();

        // R8 random groups under back-pressure
        lat_chk  = 0;
        stall_en = 1;
        for (int g = 0; g < 30; g++) begin
            int m = $urandom % 4;
            int n = 1 + $urandom % 4;
            for (int i = 0; i < n; i++)
                send(rand_line(), m, n, i == 0, i == n - 1, "R8 stalled stream");
        end
        idle(); drain();
        stall_en = 0;
        chk_int(exp_q.size() == 0, "R8 all beats delivered", exp_q.size(), 0);

        done = 1;
        summary();
        $finish;
    end
endmodule